// File: doc/BRIEF.md
# Dual-Class Register File with Two-Pass 16-Bit ALU

This block holds two banks of general registers, eight for data and eight for addresses, each 32 bits wide. It executes one arithmetic or logic operation per start strobe. The destination register is always one operand. The other operand is either a second register or an immediate or memory value presented on the block's inputs. The arithmetic unit is only 16 bits wide, so a 32-bit operation runs as two passes, low half first and then high half. The carry or borrow of the first pass is held in a register and fed into the second.

The class of the destination register decides how the condition flags behave. A result written to a data register updates negative, zero, overflow and carry. A result written to an address register leaves all four flags as they were, so pointer arithmetic can be mixed into a flag-dependent data sequence. A 16-bit value headed for an address register is sign-extended to 32 bits first, which lets short addresses near the top or bottom of the space be given in 16 bits. All 32 address bits are kept in the register, but only the low 24 bits of one selectable address register leave the block on the external address output.

Instruction decode, bus cycles and effective-address sequencing happen elsewhere. The caller presents fully decoded fields and waits for `done`.

Top module: `dcrf_core`

## Requirements
- R1: After reset every register reads zero, `flags` is 0, `done` is low and `ext_addr` is 0.
- R2: With a data-register destination, `flags` = {N,Z,V,C} (bit 3 down to bit 0) is updated from the result at the most significant bit of the selected size. `op` codes: 0 move (result = source), 1 add (dst + src), 2 subtract (dst - src, C = borrow), 3 and. Move and and clear V and C.
- R3: With an address-register destination (`dst_cls` = 1), `flags` keeps its previous value.
- R4: `size` codes: 0 byte, 1 word, 2 long. A byte or word result written to a data register replaces only the low 8 or 16 bits; the upper bits keep their old value.
- R5: With an address-register destination and a byte or word size, the low 16 bits of the source are sign-extended to 32 bits. The operation is then done on all 32 bits and the full register is written.
- R6: A long operation forms its 32-bit result from two 16-bit passes, with the carry or borrow of the low pass entering the high pass. Its Z flag is set only when both halves are zero.
- R7: `done` is high for exactly one cycle. It rises after the 2nd rising edge counted from the edge that samples `start` for a byte or word data operation, and after the 3rd for a long data operation or any address-register operation. `result` then shows the full new 32-bit value of the destination.
- R8: `ext_addr` carries the low 24 bits of the address register chosen by `addr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled while idle |
| op | input | 2 | Operation code (move, add, subtract, and) |
| size | input | 2 | Operand size (byte, word, long) |
| dst_cls | input | 1 | Destination class: 0 data, 1 address |
| dst_idx | input | 3 | Destination register index |
| src_imm | input | 1 | 1: source is `imm`; 0: source is a register |
| src_cls | input | 1 | Source register class |
| src_idx | input | 3 | Source register index |
| imm | input | 32 | Immediate or memory operand |
| addr_idx | input | 3 | Address register shown on `ext_addr` |
| result | output | 32 | New value of the destination register |
| flags | output | 4 | Condition flags {N,Z,V,C} |
| done | output | 1 | One-cycle completion pulse |
| ext_addr | output | 24 | Low 24 bits of the selected address register |

## Verification
The bench targets the carry crossing from the low pass into the high pass. If the carry is dropped, 0x0000FFFF + 1 yields 0 and not 0x00010000, and a long subtract that borrows in the low half gives a wrong upper word. It also covers a long sum whose low half alone is zero, where a design that takes Z from one half would set it wrongly. It also checks that a byte add leaves bits 31..8 intact, and that an address-register write neither touches the flags nor fails to sign-extend a word value such as 0x8000. The bench measures latency for each size, because a design that skipped or added a pass would shift the pulse on `done`.

// File: rtl/dcrf_pkg.sv
// Shared types for the dual-class register file.
// Assumes a 2-bit op code and a 2-bit size code as listed in the brief.
package dcrf_pkg;
    typedef enum logic [1:0] {
        OP_MOVE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_AND  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } op_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } pass_e;
endpackage

// File: rtl/dcrf_regs.sv
// Register storage: NREG data registers followed by NREG address
// registers, addressed by {class, index}. Two read ports for operands,
// one narrow port for the external address, one write port.
// Assumes at most one write per cycle; writes land at the clock edge.
module dcrf_regs #(
    parameter  int NREG       = 8,
    parameter  int REG_W      = 32,
    parameter  int EXT_ADDR_W = 24,
    localparam int IDX_W      = $clog2(NREG),
    localparam int SEL_W      = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [SEL_W-1:0]      rd_a_sel,
    output logic [REG_W-1:0]      rd_a_data,
    input  logic [SEL_W-1:0]      rd_b_sel,
    output logic [REG_W-1:0]      rd_b_data,
    input  logic [IDX_W-1:0]      ext_idx,
    output logic [EXT_ADDR_W-1:0] ext_data
);
    localparam int NENT = 2 * NREG;

    logic [REG_W-1:0] bank [NENT];

    for (genvar g = 0; g < NENT; g++) begin : g_reg
        // Hold one register; load it when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                bank[g] <= wr_data;
            end
        end
    end

    // Operand and address read ports.
    always_comb begin
        rd_a_data = bank[rd_a_sel];
        rd_b_data = bank[rd_b_sel];
        ext_data  = bank[{1'b1, ext_idx}][EXT_ADDR_W-1:0];
    end
endmodule

// File: rtl/dcrf_sext.sv
// Sign extension from IN_W to OUT_W bits; used to widen short
// address operands. Assumes OUT_W > IN_W.
module dcrf_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    // Replicate the top input bit into the upper part.
    always_comb dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
endmodule

// File: rtl/dcrf_alu.sv
// One W-bit arithmetic pass with carry in. In narrow mode carry and
// overflow are taken at bit W/2-1 instead of W-1. For subtract, cin and
// cout mean borrow. Move and and report no carry and no overflow.
module dcrf_alu
    import dcrf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    input  logic         narrow,
    output logic [W-1:0] y,
    output logic         cout,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W:0]  sum_w, dif_w;
    logic [HW:0] sum_n, dif_n;
    logic        sa, sb, sy;

    // Full and half width sums and differences.
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        dif_w = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        sum_n = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        dif_n = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
    end

    // Select result, carry and overflow for the operation.
    always_comb begin
        y    = b;
        cout = 1'b0;
        ovf  = 1'b0;
        sa   = narrow ? a[HW-1] : a[W-1];
        sb   = narrow ? b[HW-1] : b[W-1];
        unique case (op)
            OP_ADD: begin
                y    = sum_w[W-1:0];
                sy   = narrow ? y[HW-1] : y[W-1];
                cout = narrow ? sum_n[HW] : sum_w[W];
                ovf  = (sa == sb) && (sy != sa);
            end
            OP_SUB: begin
                y    = dif_w[W-1:0];
                sy   = narrow ? y[HW-1] : y[W-1];
                cout = narrow ? dif_n[HW] : dif_w[W];
                ovf  = (sa != sb) && (sy != sa);
            end
            OP_AND: begin
                y  = a & b;
                sy = 1'b0;
            end
            default: begin
                y  = b;
                sy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dcrf_core.sv
// Dual-class register file with a half-width ALU. On start, latches the
// destination value and the source value (sign-extended for short
// address operands), then runs one ALU pass for byte/word data
// operations or two passes (low, high) otherwise. Flags change only
// when the destination is a data register.
// Assumes start is presented only while done-waiting is not in progress;
// a start during a busy operation is ignored.
module dcrf_core
    import dcrf_pkg::*;
#(
    parameter  int NREG       = 8,
    parameter  int WORD_W     = 16,
    parameter  int EXT_ADDR_W = 24,
    localparam int REG_W      = 2 * WORD_W,
    localparam int IDX_W      = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            op,
    input  logic [1:0]            size,
    input  logic                  dst_cls,
    input  logic [IDX_W-1:0]      dst_idx,
    input  logic                  src_imm,
    input  logic                  src_cls,
    input  logic [IDX_W-1:0]      src_idx,
    input  logic [REG_W-1:0]      imm,
    input  logic [IDX_W-1:0]      addr_idx,
    output logic [REG_W-1:0]      result,
    output logic [3:0]            flags,
    output logic                  done,
    output logic [EXT_ADDR_W-1:0] ext_addr
);
    localparam int SEL_W  = IDX_W + 1;
    localparam int BYTE_W = WORD_W / 2;

    pass_e              state;
    alu_op_e            op_q;
    logic [SEL_W-1:0]   dst_sel_q;
    logic               narrow_q, long_q;
    logic [REG_W-1:0]   a_q, b_q;
    logic [WORD_W-1:0]  lo_y_q;
    logic               lo_c_q, lo_z_q;

    logic [REG_W-1:0]   rd_a_data, rd_b_data, b_src, b_ext, b_in;
    logic [WORD_W-1:0]  alu_a, alu_b, alu_y;
    logic               alu_cin, alu_c, alu_v, alu_narrow;
    logic               wr_en, nf, zf;
    logic [REG_W-1:0]   wr_data;
    logic               is_long, is_narrow;

    dcrf_regs #(
        .NREG(NREG), .REG_W(REG_W), .EXT_ADDR_W(EXT_ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(dst_sel_q), .wr_data(wr_data),
        .rd_a_sel({dst_cls, dst_idx}), .rd_a_data(rd_a_data),
        .rd_b_sel({src_cls, src_idx}), .rd_b_data(rd_b_data),
        .ext_idx(addr_idx), .ext_data(ext_addr)
    );

    dcrf_sext #(.IN_W(WORD_W), .OUT_W(REG_W)) u_sext (
        .din(b_src[WORD_W-1:0]), .dout(b_ext)
    );

    dcrf_alu #(.W(WORD_W)) u_alu (
        .a(alu_a), .b(alu_b), .cin(alu_cin), .op(op_q),
        .narrow(alu_narrow), .y(alu_y), .cout(alu_c), .ovf(alu_v)
    );

    // Source selection and operand-shape decode at start.
    always_comb begin
        b_src     = src_imm ? imm : rd_b_data;
        is_long   = dst_cls || (size[1] == 1'b1);
        is_narrow = !dst_cls && (size == SZ_BYTE);
        b_in      = (dst_cls && !size[1]) ? b_ext : b_src;
    end

    // Feed the ALU the low or high half depending on the pass.
    always_comb begin
        if (state == ST_HI) begin
            alu_a      = a_q[REG_W-1:WORD_W];
            alu_b      = b_q[REG_W-1:WORD_W];
            alu_cin    = lo_c_q;
            alu_narrow = 1'b0;
        end else begin
            alu_a      = a_q[WORD_W-1:0];
            alu_b      = b_q[WORD_W-1:0];
            alu_cin    = 1'b0;
            alu_narrow = narrow_q;
        end
    end

    // Write-back data, merge of narrow results, and flag values.
    always_comb begin
        wr_en = (state == ST_HI) || ((state == ST_LO) && !long_q);
        if (state == ST_HI) begin
            wr_data = {alu_y, lo_y_q};
            nf      = alu_y[WORD_W-1];
            zf      = lo_z_q && (alu_y == '0);
        end else if (narrow_q) begin
            wr_data = {a_q[REG_W-1:BYTE_W], alu_y[BYTE_W-1:0]};
            nf      = alu_y[BYTE_W-1];
            zf      = (alu_y[BYTE_W-1:0] == '0);
        end else begin
            wr_data = {a_q[REG_W-1:WORD_W], alu_y};
            nf      = alu_y[WORD_W-1];
            zf      = (alu_y == '0);
        end
    end

    // Pass sequencer and operand latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= OP_MOVE;
            dst_sel_q <= '0;
            narrow_q  <= 1'b0;
            long_q    <= 1'b0;
            a_q       <= '0;
            b_q       <= '0;
            lo_y_q    <= '0;
            lo_c_q    <= 1'b0;
            lo_z_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_LO;
                    op_q      <= alu_op_e'(op);
                    dst_sel_q <= {dst_cls, dst_idx};
                    narrow_q  <= is_narrow;
                    long_q    <= is_long;
                    a_q       <= rd_a_data;
                    b_q       <= b_in;
                end
                ST_LO: begin
                    lo_y_q <= alu_y;
                    lo_c_q <= alu_c;
                    lo_z_q <= (alu_y == '0);
                    state  <= long_q ? ST_HI : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs: result, done pulse, and flags for data destinations only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flags  <= '0;
            done   <= 1'b0;
        end else begin
            done <= wr_en;
            if (wr_en) begin
                result <= wr_data;
                if (!dst_sel_q[SEL_W-1]) begin
                    flags <= {nf, zf, alu_v, alu_c};
                end
            end
        end
    end
endmodule

// File: rtl/dcrf_checks.sv
// Protocol checks for dcrf_core, attached by bind.
module dcrf_checks
    import dcrf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [3:0] flags,
    input logic       wr_en,
    input logic       wr_addr_cls,
    input pass_e      state
);
    // R1: reset clears flags and done
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flags == 4'd0 && !done));

    // R3: an address-register write leaves the flags alone
    p_addr_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr_cls) |=> $stable(flags));

    // R6: the high pass always follows a low pass
    p_hi_after_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI) |-> ($past(state) == ST_LO));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: no write-back while idle
    p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !wr_en);
endmodule

bind dcrf_core dcrf_checks u_checks (
    .clk(clk), .rst_n(rst_n), .done(done), .flags(flags),
    .wr_en(wr_en), .wr_addr_cls(dst_sel_q[SEL_W-1]), .state(state)
);

// File: tb/dcrf_core_bench.sv
// Scoreboard bench: the driver predicts each result into a queue, the
// monitor pops and compares when done pulses.
module dcrf_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op, size;
    logic        dst_cls, src_imm, src_cls;
    logic [2:0]  dst_idx, src_idx, addr_idx;
    logic [31:0] imm;
    logic [31:0] result;
    logic [3:0]  flags;
    logic        done;
    logic [23:0] ext_addr;

    always #5 clk = ~clk;

    dcrf_core u_dcrf_core (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .dst_cls(dst_cls), .dst_idx(dst_idx), .src_imm(src_imm),
        .src_cls(src_cls), .src_idx(src_idx), .imm(imm),
        .addr_idx(addr_idx), .result(result), .flags(flags),
        .done(done), .ext_addr(ext_addr)
    );

    typedef struct {
        logic [31:0] res;
        logic [3:0]  flg;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] m_reg [16];
    logic [3:0]  m_flg;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each done pulse against the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(result == e.res, e.tag, "result", result, e.res);
                check(flags == e.flg, e.tag, "flags", {28'd0, flags}, {28'd0, e.flg});
            end
        end
    end

    // Driver: predict, push, issue, and time the operation.
    task automatic run_op(input logic [1:0] o, input logic [1:0] sz,
                          input logic dc, input logic [2:0] di,
                          input logic si, input logic sc, input logic [2:0] sx,
                          input logic [31:0] iv, input string tag);
        logic [31:0] a, b, nv;
        logic [63:0] av, bv, rr, mask;
        logic        c, v;
        int          n, edges, want;
        exp_t        e;
        a = m_reg[{dc, di}];
        b = si ? iv : m_reg[{sc, sx}];
        if (dc) begin
            if (sz != 2'd2) b = {{16{b[15]}}, b[15:0]};
            n = 32;
        end else begin
            n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        end
        mask = (64'd1 << n) - 64'd1;
        av = {32'd0, a} & mask;
        bv = {32'd0, b} & mask;
        c = 1'b0; v = 1'b0;
        case (o)
            2'd1: begin
                rr = av + bv;
                c  = rr[n];
                v  = (av[n-1] == bv[n-1]) && (rr[n-1] != av[n-1]);
            end
            2'd2: begin
                rr = av - bv;
                c  = (bv > av);
                v  = (av[n-1] != bv[n-1]) && (rr[n-1] != av[n-1]);
            end
            2'd3: rr = av & bv;
            default: rr = bv;
        endcase
        nv = (a & ~mask[31:0]) | (rr[31:0] & mask[31:0]);
        m_reg[{dc, di}] = nv;
        if (!dc) m_flg = {rr[n-1], ((rr & mask) == 64'd0), v, c};
        e.res = nv; e.flg = m_flg; e.tag = tag;
        sb_q.push_back(e);
        want = (n == 32) ? 3 : 2;

        @(negedge clk);
        op = o; size = sz; dst_cls = dc; dst_idx = di;
        src_imm = si; src_cls = sc; src_idx = sx; imm = iv;
        start = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && edges < 20) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        check(edges == want, "R7", "latency", edges, want);
        @(negedge clk);
        check(!done, "R7", "done width", {31'd0, done}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 32'd0;
        m_flg = 4'd0;
        rst_n = 1'b0; start = 1'b0; op = 2'd0; size = 2'd0;
        dst_cls = 1'b0; dst_idx = 3'd0; src_imm = 1'b0; src_cls = 1'b0;
        src_idx = 3'd0; imm = 32'd0; addr_idx = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(flags == 4'd0, "R1", "flags", {28'd0, flags}, 32'd0);
        check(!done, "R1", "done", {31'd0, done}, 32'd0);
        check(ext_addr == 24'd0, "R1", "ext_addr", {8'd0, ext_addr}, 32'd0);
        run_op(2'd0, 2'd2, 1'b0, 3'd6, 1'b0, 1'b1, 3'd5, 32'd0, "R1");

        // R2: word add crossing into the sign bit sets N and V
        run_op(2'd0, 2'd2, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 32'h0000_7FFF, "R2");
        run_op(2'd1, 2'd1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 32'h0000_0001, "R2");

        // R4: byte add wraps to zero with carry, upper bits kept
        run_op(2'd0, 2'd2, 1'b0, 3'd1, 1'b1, 1'b0, 3'd0, 32'h1234_56FF, "R4");
        run_op(2'd1, 2'd0, 1'b0, 3'd1, 1'b1, 1'b0, 3'd0, 32'h0000_0001, "R4");

        // R6: carry from low pass into high pass; low half zero but Z clear
        run_op(2'd0, 2'd2, 1'b0, 3'd2, 1'b1, 1'b0, 3'd0, 32'h0000_FFFF, "R6");
        run_op(2'd1, 2'd2, 1'b0, 3'd2, 1'b1, 1'b0, 3'd0, 32'h0000_0001, "R6");
        // R6: both halves zero gives Z with carry out
        run_op(2'd0, 2'd2, 1'b0, 3'd3, 1'b1, 1'b0, 3'd0, 32'hFFFF_0000, "R6");
        run_op(2'd1, 2'd2, 1'b0, 3'd3, 1'b1, 1'b0, 3'd0, 32'h0001_0000, "R6");
        // R6: borrow chained through a long subtract
        run_op(2'd2, 2'd2, 1'b0, 3'd5, 1'b1, 1'b0, 3'd0, 32'h0000_0001, "R6");

        // R2: word subtract from zero sets N and C
        run_op(2'd2, 2'd1, 1'b0, 3'd4, 1'b1, 1'b0, 3'd0, 32'h0000_0001, "R2");

        // R3 and R5: address writes sign-extend and keep flags
        run_op(2'd0, 2'd1, 1'b1, 3'd2, 1'b1, 1'b0, 3'd0, 32'h0000_8000, "R5");
        run_op(2'd1, 2'd0, 1'b1, 3'd2, 1'b1, 1'b0, 3'd0, 32'h0000_00FF, "R3");
        run_op(2'd1, 2'd2, 1'b1, 3'd2, 1'b0, 1'b0, 3'd2, 32'd0, "R3");

        // R8: external address shows low 24 bits
        run_op(2'd0, 2'd2, 1'b1, 3'd3, 1'b1, 1'b0, 3'd0, 32'hFEDC_BA98, "R8");
        addr_idx = 3'd3;
        @(negedge clk);
        check(ext_addr == 24'hDC_BA98, "R8", "ext_addr A3", {8'd0, ext_addr}, 32'h00DC_BA98);
        addr_idx = 3'd2;
        @(negedge clk);
        check(ext_addr == m_reg[10][23:0], "R8", "ext_addr A2", {8'd0, ext_addr}, {8'd0, m_reg[10][23:0]});

        // R2: register-source and clears V and C
        run_op(2'd3, 2'd1, 1'b0, 3'd1, 1'b0, 1'b0, 3'd0, 32'd0, "R2");
        // R2: byte move of a negative value
        run_op(2'd0, 2'd0, 1'b0, 3'd7, 1'b1, 1'b0, 3'd0, 32'h0000_0080, "R2");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7", "pending results", sb_q.size(), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule